// File: doc/BRIEF.md
# Serial-Loaded Potentiometer Wiper Controller

This block is the digital front end of a 256-step variable resistor. A host writes an 8-bit wiper setting over a three-wire serial link: an active-low select, a serial clock and a data line. Bits are shifted in most significant first while select is low. The word is committed to the wiper register only when select goes high again, so the resistor never passes through partial settings.

The serial pins run without any timing relation to the system clock. Each pin passes through a two-flop synchroniser, and edges are detected in the system clock domain. Downstream logic receives several outputs: the wiper code, its complement for the opposite side of the resistor, a scaled divider value, a one-cycle strobe on every change, and a busy flag. The busy flag covers a programmable settling window after each change.

Top module: `digipot_wiper_ctrl`

## Requirements
- R1: While reset is applied and afterwards, until the first commit, the wiper code is midscale 0x80, the complement is 0x7F, and neither the update strobe nor the busy flag is high.
- R2: A frame of exactly 8 serial clock rising edges loads the word into the wiper register when select rises. The first bit received is bit 7 of the code.
- R3: While select is low, the wiper outputs keep the previously committed value.
- R4: Serial clock edges while select is high shift nothing and change no output.
- R5: A frame with more than 8 rising edges commits the last 8 bits received, in arrival order.
- R6: A frame with fewer than 8 rising edges is discarded, and the wiper keeps its old value.
- R7: The complement output always equals 255 minus the wiper code.
- R8: The divider output equals floor(code × DIV_SPAN / 256), with DIV_SPAN defaulting to 5000.
- R9: The update strobe is high for exactly one system clock in the cycle in which the wiper code has just changed. A commit of the value already held gives no strobe.
- R10: The busy flag rises in the same cycle as the update strobe and stays high for exactly SETTLE_CYCLES system clocks (default 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_sel_n | input | 1 | Serial frame select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge, asynchronous |
| ser_din | input | 1 | Serial data, MSB first |
| wiper_code | output | 8 | Committed wiper setting |
| wiper_comp | output | 8 | 255 minus the setting (opposite side of the resistor) |
| div_level | output | 13 | Scaled divider value |
| upd_pulse | output | 1 | One-cycle strobe when the wiper changes |
| settle_busy | output | 1 | High during the settling window |

## Verification
The assertions assume that each serial clock level and each select level lasts for several system clocks. They also assume that data is stable across the synchronised clock rise, and that no serial clock edge coincides with a select edge after synchronisation. The stimulus keeps serial clock half-periods at five system clocks and changes data only while the serial clock is low. It leaves at least four system clocks between select edges and the nearest clock edge. Random frames vary the word and the bit count, and insert stray clocks while select is high. Directed frames cover zero, full scale, repeated values and short and long frames.

// File: rtl/digipot_wiper_ctrl.sv
module digipot_wiper_ctrl #(
  parameter int CODE_W        = 8,
  parameter int SETTLE_CYCLES = 16,
  parameter int DIV_SPAN      = 5000,
  localparam int DIV_W = $clog2(DIV_SPAN + 1),
  localparam int CNT_W = $clog2(CODE_W + 1),
  localparam int STL_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic [CODE_W-1:0] wiper_code,
  output logic [CODE_W-1:0] wiper_comp,
  output logic [DIV_W-1:0]  div_level,
  output logic              upd_pulse,
  output logic              settle_busy
);

  localparam logic [CODE_W-1:0] MID_CODE  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(CODE_W);
  localparam logic [STL_W-1:0]  STL_LOAD  = STL_W'(SETTLE_CYCLES);
  localparam int                PROD_W    = CODE_W + DIV_W;

  logic [2:0] sel_sr, sclk_sr;
  logic [1:0] din_sr;
  logic [CODE_W-1:0] shift_q;
  logic [CNT_W-1:0]  bits_q;
  logic [STL_W-1:0]  stl_q;
  logic [PROD_W-1:0] prod;

  wire sel_fall  = sel_sr[2] & ~sel_sr[1];
  wire sel_rise  = ~sel_sr[2] & sel_sr[1];
  wire sclk_rise = ~sclk_sr[2] & sclk_sr[1];
  wire commit    = sel_rise && (bits_q == FULL_CNT);
  wire changes   = commit && (shift_q != wiper_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sr  <= 3'b111;
      sclk_sr <= 3'b000;
      din_sr  <= 2'b00;
    end else begin
      sel_sr  <= {sel_sr[1:0], ser_sel_n};
      sclk_sr <= {sclk_sr[1:0], ser_clk};
      din_sr  <= {din_sr[0], ser_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      bits_q  <= '0;
    end else if (sel_fall) begin
      bits_q <= '0;
    end else if (!sel_sr[1] && sclk_rise) begin
      shift_q <= {shift_q[CODE_W-2:0], din_sr[1]};
      if (bits_q != FULL_CNT) bits_q <= bits_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_code <= MID_CODE;
      upd_pulse  <= 1'b0;
      stl_q      <= '0;
    end else begin
      upd_pulse <= changes;
      if (commit) wiper_code <= shift_q;
      if (changes) stl_q <= STL_LOAD;
      else if (stl_q != '0) stl_q <= stl_q - 1'b1;
    end
  end

  assign wiper_comp  = ~wiper_code;
  assign prod        = PROD_W'(wiper_code) * PROD_W'(DIV_SPAN);
  assign div_level   = prod[CODE_W +: DIV_W];
  assign settle_busy = (stl_q != '0);

  AST_RESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (wiper_code == MID_CODE && !upd_pulse && !settle_busy)); // R1
  AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_sr[1] |=> $stable(wiper_code)); // R3
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && bits_q != FULL_CNT) |=> $stable(wiper_code)); // R6
  AST_SUM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (CODE_W + 1)'(wiper_code) + (CODE_W + 1)'(wiper_comp) == (CODE_W + 1)'((1 << CODE_W) - 1)); // R7
  AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_code != $past(wiper_code)) |-> upd_pulse); // R9
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse); // R9
  AST_BUSY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> settle_busy); // R10

endmodule

// File: tb/digipot_wiper_ctrl_tb_top.sv
module digipot_wiper_ctrl_tb_top;
  localparam int SETTLE = 16;
  localparam int SPAN   = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [7:0] w, wc;
  logic [12:0] dv;
  logic upd, busy;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] model = 8'h80;

  always #2 clk = ~clk;

  digipot_wiper_ctrl #(.CODE_W(8), .SETTLE_CYCLES(SETTLE), .DIV_SPAN(SPAN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sclk), .ser_din(din),
    .wiper_code(w), .wiper_comp(wc), .div_level(dv), .upd_pulse(upd), .settle_busy(busy));

  function automatic int exp_div(input logic [7:0] c);
    return (int'(c) * SPAN) / 256;
  endfunction

  function automatic int exp_comp(input logic [7:0] c);
    return 255 - int'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int nbits, input logic [31:0] bits);
    tick(1); sel_n = 1'b0; tick(5);
    for (int i = nbits - 1; i >= 0; i--) begin
      din = bits[i]; tick(5);
      sclk = 1'b1; tick(5);
      sclk = 1'b0;
      if (i == nbits - 4) chk(w == model, "R3 hold during frame", w, model);
    end
    tick(5); sel_n = 1'b1;
  endtask

  task automatic expect_result(input bit change);
    bit seen = 1'b0;
    int blen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      tick(1);
      if (upd) seen = 1'b1;
    end
    if (change) begin
      chk(seen, "R9 strobe on change", seen, 1);
      chk(w == model, "R2 committed code", w, model);
      chk(int'(wc) == exp_comp(model), "R7 complement", wc, exp_comp(model));
      chk(int'(dv) == exp_div(model), "R8 divider", dv, exp_div(model));
      if (seen) begin
        while (busy && blen < 100) begin blen++; tick(1); end
        chk(blen == SETTLE, "R10 busy length", blen, SETTLE);
        chk(!upd, "R9 strobe single cycle", upd, 0);
      end
    end else begin
      chk(!seen, "R9 no strobe without change", seen, 0);
      chk(w == model, "R6 wiper kept", w, model);
    end
    tick(SETTLE + 4);
  endtask

  task automatic stray_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      din = $urandom_range(0, 1); tick(5);
      sclk = 1'b1; tick(5); sclk = 1'b0;
      chk(!upd && w == model, "R4 stray clock ignored", w, model);
    end
    tick(10);
    chk(w == model && !busy, "R4 after stray clocks", w, model);
  endtask

  task automatic run_frame(input int nbits, input logic [31:0] bits);
    logic [7:0] nw = bits[7:0];
    bit ch;
    send_frame(nbits, bits);
    ch = (nbits >= 8) && (nw != model);
    if (nbits >= 8) model = nw;
    expect_result(ch);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tick(3);
    chk(w == 8'h80, "R1 reset code", w, 128);
    chk(wc == 8'h7F, "R1 reset complement", wc, 127);
    chk(!upd && !busy, "R1 reset flags", {upd, busy}, 0);
    rst_n = 1'b1; tick(4);
    chk(w == 8'h80 && !busy, "R1 after reset", w, 128);
    stray_clocks(6);
    run_frame(8, 32'h00);
    run_frame(8, 32'hFF);
    run_frame(8, 32'hA5);
    run_frame(8, 32'hA5);
    run_frame(11, 32'h5C3);
    chk(w == 8'hC3, "R5 last eight bits", w, 8'hC3);
    run_frame(5, 32'h1F);
    chk(w == 8'hC3, "R6 short frame dropped", w, 8'hC3);
    run_frame(7, 32'h7F);
    for (int k = 0; k < 60; k++) begin
      int nb = ($urandom_range(0, 3) == 0) ? int'($urandom_range(4, 12)) : 8;
      run_frame(nb, $urandom);
      if ($urandom_range(0, 4) == 0) stray_clocks(3);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule